// File: doc/BRIEF.md
# Panel Register Write Sequencer

This block configures a TFT panel controller over a write-only SPI link. Every register write goes out as two separate 24-bit transactions. The first selects the register: a select command byte, a zero byte, then the register number. The second carries a data command byte and the 16-bit value, high byte first. Each transaction has its own chip-select window. Register numbers, values and their order are built into the block as three fixed sequences: bring-up, power-down and wake-up.

The host starts a sequence by pulsing one of three command inputs for a cycle. `busy` stays high until the last transaction of the sequence has left the block. `done` then pulses for one cycle. The output control word is a fixed base value with a group of configurable bits replaced from the `mode_bits` input. It is captured when the command is accepted.

Top module: `panel_cfg_seq`

## Requirements
- R1: A select transaction is 24 bits, sent MSB first: 0x74, 0x00, then the 8-bit register number. For any one register write it always goes out before that write's data transaction.
- R2: A data transaction is 24 bits, sent MSB first: 0x76, the value's high byte, then its low byte.
- R3: A bring-up command (`cmd_power_on`) writes 0x0000 to register 0x11 and then the output control word to register 0x01.
- R4: A wake-up command (`cmd_resume`) writes the output control word to register 0x01 and then 0x0000 to register 0x11.
- R5: A power-down command (`cmd_shutdown`) performs exactly one write: 0x0001 to register 0x11. Bit 0 of that register set means panel off.
- R6: The output control word is (0x2AEF & ~MODE_MASK) | (mode_bits & MODE_MASK). MODE_MASK defaults to 0x3C00. `mode_bits` is sampled in the accepting cycle, and later changes have no effect on the running sequence.
- R7: The SPI link runs in mode 0. SCK idles low and stays low while chip select is high. MOSI changes only while SCK is low. SCK has a period of 2*CLK_DIV clock cycles, and chip select stays low for all 24 bits of a transaction.
- R8: Between two transactions, chip select stays high for at least one SCK period (2*CLK_DIV clock cycles).
- R9: After reset, chip select is high, SCK is low, and `busy` and `done` are low. `busy` goes high in the cycle after a command is accepted. It falls in the same cycle that `done` pulses for one cycle, and `done` pulses once per accepted command.
- R10: A command presented while `busy` is high is ignored. It causes no transaction and no `done` pulse.
- R11: When several commands are presented in the same accepting cycle, power-down wins over bring-up, and bring-up wins over wake-up.
- R12: A command presented in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_power_on | input | 1 | Start the bring-up sequence |
| cmd_shutdown | input | 1 | Start the power-down sequence |
| cmd_resume | input | 1 | Start the wake-up sequence |
| mode_bits | input | 16 | Source for the configurable control-word bits |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI serial data out |

## Verification
Two events can meet in one cycle: the completion of a sequence (`done` high, `busy` falling) and the arrival of a new command. The bench provokes this by watching for `done` and raising a command in that same cycle. It judges the result from the SPI line: the full frame list of the new sequence must appear after the old one, with the correct chip-select gap. Commands that arrive together, and commands raised in the middle of a sequence, are judged the same way. Only frames of the winning sequence may appear, and there must be exactly one `done` pulse per accepted command.

// File: rtl/panel_seq_pkg.sv
// Shared constants, types and frame builders for the panel sequencer.
// Assumes 8-bit register numbers and 16-bit register values.
package panel_seq_pkg;

    localparam int FRAME_BITS = 24;
    localparam int MAX_STEPS  = 4;
    localparam int STEP_W     = $clog2(MAX_STEPS);

    localparam logic [7:0]  SEL_CMD     = 8'h74;
    localparam logic [7:0]  DAT_CMD     = 8'h76;
    localparam logic [7:0]  REG_POWER   = 8'h11;
    localparam logic [7:0]  REG_OUTCTL  = 8'h01;
    localparam logic [15:0] OUTCTL_BASE = 16'h2AEF;
    localparam logic [15:0] POWER_OFF   = 16'h0001;
    localparam logic [15:0] POWER_RUN   = 16'h0000;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_BRINGUP  = 2'd1,
        OP_POWERDN  = 2'd2,
        OP_WAKEUP   = 2'd3
    } seq_op_e;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] value;
    } reg_write_t;

    // Builds the register-select transaction.
    function automatic logic [FRAME_BITS-1:0] select_frame(input logic [7:0] addr);
        return {SEL_CMD, 8'h00, addr};
    endfunction

    // Builds the data transaction.
    function automatic logic [FRAME_BITS-1:0] value_frame(input logic [15:0] value);
        return {DAT_CMD, value};
    endfunction

endpackage

// File: rtl/spi_frame_tx.sv
// Sends one frame of FRAME_BITS bits, MSB first, in SPI mode 0.
// Chip select is low for the whole frame. After the frame it is held high
// for one full SCK period, and only then is xfer_done pulsed.
// Assumes start is pulsed only while the engine is idle.
module spi_frame_tx #(
    parameter int CLK_DIV    = 2,
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  xfer_done,
    output logic                  cs_n,
    output logic                  sck,
    output logic                  mosi
);

    localparam int EDGES   = 2 * FRAME_BITS;
    localparam int EDGE_W  = $clog2(EDGES);
    localparam int GAP_CYC = 2 * CLK_DIV;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;

    tx_state_e             state;
    logic [FRAME_BITS-1:0] shreg;
    logic [EDGE_W-1:0]     edge_cnt;
    logic [GAP_W-1:0]      gap_cnt;
    logic                  half_tick;

    // Half-period tick: every cycle when CLK_DIV is 1, else from a divider.
    generate
        if (CLK_DIV == 1) begin : g_nodiv
            assign half_tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(CLK_DIV);
            logic [DIV_W-1:0] div_cnt;
            // Count system clocks within one SCK half period.
            always_ff @(posedge clk) begin
                if (!rst_n || state != TX_SHIFT) begin
                    div_cnt <= '0;
                end else if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
            assign half_tick = (div_cnt == DIV_W'(CLK_DIV - 1));
        end
    endgenerate

    // Frame state machine: load, shift on falling SCK, then the CS gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            shreg     <= '0;
            edge_cnt  <= '0;
            gap_cnt   <= '0;
            cs_n      <= 1'b1;
            sck       <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg    <= frame;
                        edge_cnt <= '0;
                        cs_n     <= 1'b0;
                        sck      <= 1'b0;
                        state    <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (half_tick) begin
                        if (edge_cnt == EDGE_W'(EDGES - 1)) begin
                            sck     <= 1'b0;
                            cs_n    <= 1'b1;
                            gap_cnt <= '0;
                            state   <= TX_GAP;
                        end else begin
                            edge_cnt <= edge_cnt + 1'b1;
                            sck      <= ~sck;
                            if (sck) begin
                                shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                            end
                        end
                    end
                end
                TX_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                        state     <= TX_IDLE;
                        xfer_done <= 1'b1;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign mosi = ~cs_n & shreg[FRAME_BITS-1];

endmodule

// File: rtl/panel_cmd_arb.sv
// Picks one command from the three request pulses by fixed priority
// (power-down, then bring-up, then wake-up) and accepts it only when idle.
// Assumes the requests are synchronous to clk.
module panel_cmd_arb
    import panel_seq_pkg::*;
(
    input  logic    req_bringup,
    input  logic    req_powerdn,
    input  logic    req_wakeup,
    input  logic    busy,
    output logic    accept,
    output seq_op_e op
);

    // Priority select and acceptance gate.
    always_comb begin
        if (req_powerdn)      op = OP_POWERDN;
        else if (req_bringup) op = OP_BRINGUP;
        else if (req_wakeup)  op = OP_WAKEUP;
        else                  op = OP_NONE;
        accept = !busy && (op != OP_NONE);
    end

endmodule

// File: rtl/panel_seq_ctrl.sv
// Walks an accepted sequence one transaction at a time: for each register
// write it sends a select frame and then a data frame to the SPI engine.
// It captures the opcode and the output control word on acceptance.
// Assumes xfer_done pulses once for each start.
module panel_seq_ctrl
    import panel_seq_pkg::*;
#(
    parameter logic [15:0] MODE_MASK = 16'h3C00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  seq_op_e               op_in,
    input  logic [15:0]           mode_in,
    input  logic                  xfer_done,
    output logic                  start,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  busy,
    output logic                  done
);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

    seq_state_e        state;
    seq_op_e           op_q;
    logic [15:0]       ctrl_q;
    logic [STEP_W-1:0] step_q;
    logic              last_step;
    reg_write_t        wr;

    // Sequencing FSM with capture of opcode and control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_NONE;
            ctrl_q <= '0;
            step_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        op_q   <= op_in;
                        ctrl_q <= (OUTCTL_BASE & ~MODE_MASK) | (mode_in & MODE_MASK);
                        step_q <= '0;
                        state  <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (xfer_done) begin
                        if (last_step) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            step_q <= step_q + 1'b1;
                            state  <= S_ISSUE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Register write for the current step of the running sequence.
    always_comb begin
        case (op_q)
            OP_BRINGUP: wr = step_q[1] ? '{REG_OUTCTL, ctrl_q} : '{REG_POWER, POWER_RUN};
            OP_WAKEUP:  wr = step_q[1] ? '{REG_POWER, POWER_RUN} : '{REG_OUTCTL, ctrl_q};
            default:    wr = '{REG_POWER, POWER_OFF};
        endcase
    end

    // Frame selection and the end-of-sequence test.
    always_comb begin
        frame     = step_q[0] ? value_frame(wr.value) : select_frame(wr.addr);
        last_step = (op_q == OP_POWERDN) ? (step_q == STEP_W'(1))
                                         : (step_q == STEP_W'(MAX_STEPS - 1));
        start     = (state == S_ISSUE);
        busy      = (state != S_IDLE);
    end

endmodule

// File: rtl/panel_cfg_seq.sv
// Top of the panel register write sequencer: command arbitration, the
// sequence controller and the SPI frame engine.
// Assumes the command inputs are single-cycle pulses, synchronous to clk.
module panel_cfg_seq
    import panel_seq_pkg::*;
#(
    parameter int          CLK_DIV   = 2,
    parameter logic [15:0] MODE_MASK = 16'h3C00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_power_on,
    input  logic        cmd_shutdown,
    input  logic        cmd_resume,
    input  logic [15:0] mode_bits,
    output logic        busy,
    output logic        done,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi
);

    logic                  accept;
    seq_op_e               op_sel;
    logic                  tx_start;
    logic                  tx_done;
    logic [FRAME_BITS-1:0] tx_frame;

    panel_cmd_arb i_arb (
        .req_bringup (cmd_power_on),
        .req_powerdn (cmd_shutdown),
        .req_wakeup  (cmd_resume),
        .busy        (busy),
        .accept      (accept),
        .op          (op_sel)
    );

    panel_seq_ctrl #(.MODE_MASK(MODE_MASK)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .op_in     (op_sel),
        .mode_in   (mode_bits),
        .xfer_done (tx_done),
        .start     (tx_start),
        .frame     (tx_frame),
        .busy      (busy),
        .done      (done)
    );

    spi_frame_tx #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_start),
        .frame     (tx_frame),
        .xfer_done (tx_done),
        .cs_n      (spi_cs_n),
        .sck       (spi_sck),
        .mosi      (spi_mosi)
    );

endmodule

// File: rtl/panel_cfg_seq_chk.sv
// Protocol checker for panel_cfg_seq: SPI mode-0 framing and the
// busy/done handshake. Attached to every panel_cfg_seq instance by bind.
module panel_cfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);

    // R9
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    sck_low_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R7
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R9
    cs_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

endmodule

bind panel_cfg_seq panel_cfg_seq_chk i_panel_cfg_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/test_panel_cfg_seq.sv
// Scoreboard bench: driver tasks queue the expected frames; a monitor
// decodes the SPI line and compares each frame as it ends.
module test_panel_cfg_seq;

    localparam int          DIV  = 2;
    localparam logic [15:0] MASK = 16'h3C00;

    typedef struct {
        logic [23:0] f;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_power_on = 1'b0;
    logic        cmd_shutdown = 1'b0;
    logic        cmd_resume = 1'b0;
    logic [15:0] mode_bits = '0;
    logic        busy, done, spi_cs_n, spi_sck, spi_mosi;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];
    int done_seen = 0;
    int done_exp = 0;
    int gap_viol = 0;
    int period_viol = 0;

    always #4 clk = ~clk;

    panel_cfg_seq #(.CLK_DIV(DIV), .MODE_MASK(MASK)) i_panel_cfg_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_power_on(cmd_power_on), .cmd_shutdown(cmd_shutdown),
        .cmd_resume(cmd_resume), .mode_bits(mode_bits),
        .busy(busy), .done(done),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [15:0] ctrl_word(input logic [15:0] m);
        return (16'h2AEF & ~MASK) | (m & MASK);
    endfunction

    task automatic push_write(input logic [7:0] a, input logic [15:0] v, input string req);
        exp_q.push_back('{{8'h74, 8'h00, a}, {req, "/R1"}});
        exp_q.push_back('{{8'h76, v}, {req, "/R2"}});
    endtask

    task automatic exp_bringup(input logic [15:0] m);
        push_write(8'h11, 16'h0000, "R3");
        push_write(8'h01, ctrl_word(m), "R3/R6");
        done_exp++;
    endtask

    task automatic exp_wakeup(input logic [15:0] m);
        push_write(8'h01, ctrl_word(m), "R4/R6");
        push_write(8'h11, 16'h0000, "R4");
        done_exp++;
    endtask

    task automatic exp_powerdn();
        push_write(8'h11, 16'h0001, "R5");
        done_exp++;
    endtask

    task automatic pulse(input bit p, input bit s, input bit r);
        cmd_power_on = p; cmd_shutdown = s; cmd_resume = r;
        @(negedge clk);
        cmd_power_on = 0; cmd_shutdown = 0; cmd_resume = 0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic finish_seq(input string req);
        wait_done();
        check(!busy, "R9", "busy at done", busy, 0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, "frames left in queue", exp_q.size(), 0);
        check(done_seen == done_exp, req, "done count", done_seen, done_exp);
    endtask

    // Monitor: decodes frames, measures SCK period and CS gap.
    initial begin
        logic [23:0] sh = '0;
        int nbits = 0;
        int sck_cnt = 0;
        int cs_hi = 0;
        bit seen_frame = 0;
        logic prev_sck = 0, prev_cs = 1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done) done_seen++;
                if (!spi_cs_n && prev_cs) begin
                    if (seen_frame && cs_hi < 2 * DIV) gap_viol++;
                    nbits = 0;
                end
                if (!spi_cs_n && spi_sck && !prev_sck) begin
                    if (nbits > 0 && sck_cnt != 2 * DIV) period_viol++;
                    sh = {sh[22:0], spi_mosi};
                    nbits++;
                    sck_cnt = 0;
                end
                if (spi_cs_n && !prev_cs) begin
                    exp_t e;
                    seen_frame = 1;
                    check(nbits == 24, "R7", "bits per frame", nbits, 24);
                    if (exp_q.size() == 0) begin
                        check(0, "R10", "unexpected frame", sh, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(sh == e.f, e.req, "frame", sh, e.f);
                    end
                end
                cs_hi = spi_cs_n ? cs_hi + 1 : 0;
                sck_cnt++;
                prev_sck = spi_sck;
                prev_cs = spi_cs_n;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1, "R9", "reset cs_n", spi_cs_n, 1);
        check(spi_sck == 0, "R9", "reset sck", spi_sck, 0);
        check(busy == 0, "R9", "reset busy", busy, 0);
        check(done == 0, "R9", "reset done", done, 0);
        rst_n = 1;
        @(negedge clk);

        // Bring-up with all mode bits clear.
        mode_bits = 16'h0000;
        exp_bringup(16'h0000);
        pulse(1, 0, 0);
        check(busy == 1, "R9", "busy after accept", busy, 1);
        finish_seq("R3");

        // Wake-up with all mode bits set.
        mode_bits = 16'hFFFF;
        exp_wakeup(16'hFFFF);
        pulse(0, 0, 1);
        finish_seq("R4");

        // Power-down.
        exp_powerdn();
        pulse(0, 1, 0);
        finish_seq("R5");

        // Mode sampled at acceptance; a command raised while busy is ignored.
        mode_bits = 16'h5A5A;
        exp_bringup(16'h5A5A);
        pulse(1, 0, 0);
        mode_bits = 16'hFFFF;
        repeat (20) @(negedge clk);
        pulse(0, 1, 0);
        pulse(0, 0, 1);
        finish_seq("R10");

        // All three at once: power-down wins.
        exp_powerdn();
        pulse(1, 1, 1);
        finish_seq("R11");

        // Bring-up and wake-up together: bring-up wins.
        mode_bits = 16'h0400;
        exp_bringup(16'h0400);
        pulse(1, 0, 1);
        finish_seq("R11");

        // Command raised in the done cycle is accepted.
        exp_powerdn();
        pulse(0, 1, 0);
        wait_done();
        mode_bits = 16'h2800;
        exp_wakeup(16'h2800);
        pulse(0, 0, 1);
        check(busy == 1, "R12", "busy after done-cycle command", busy, 1);
        finish_seq("R12");

        check(gap_viol == 0, "R8", "cs gap violations", gap_viol, 0);
        check(period_viol == 0, "R7", "sck period violations", period_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule